// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the front end of a transmit DMA engine. It steps through a circular ring of 16-byte descriptors held in memory. Each entry carries a buffer address in its first word, a status word with the hand-off flag, the packet markers and an encoded byte count in its second word, and two further words that the walker never touches. When the device owns an entry, the walker reads the buffer address and the length and issues a single frame-fetch request. Once that request has been accepted, it writes the status word back with the ownership flag cleared and pulses a transmit-done event. Entries with a broken length field go back to software without a request and raise an error pulse instead.

Software sets the ring base, the ring size and the pad enable, then releases reset. It hands a descriptor over by setting bit 31 of that entry's status word. While the entry under the walker's pointer is still owned by software, the walker keeps polling that one entry and does nothing else.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset no frame request, write or event is active, and the first memory access is a read of the status word (offset 4) of entry 0.
- R2: While the status word read back has bit 31 (ownership) at 0, the walker issues no frame request and no write, and keeps re-reading that same entry.
- R3: For an owned entry whose bits 15:12 are all ones, the frame request carries the first descriptor word as its address and a byte count of 4096 minus bits 11:0 (an encoded value of 0 means 4096).
- R4: With the pad enable set, a decoded count below 64 is requested as 64. With it clear, or for counts of 64 and above, the count is passed on unchanged.
- R5: Once the frame request has been accepted, the walker writes the status word back to entry base + 16*index + 4 with bit 31 cleared and every other bit unchanged, then pulses tx_done for one cycle.
- R6: An owned entry whose bits 15:12 are not all ones gets no frame request. Its status word is written back with bit 31 cleared and desc_err pulses for one cycle. tx_done and desc_err never pulse in the same cycle.
- R7: The entry index steps by one after each write-back and wraps to 0 after the last entry. The entry count is 65536 minus the 16-bit ring length input (0 means 65536).
- R8: Bits 3:0 of the ring base input are treated as zero when descriptor addresses are formed.
- R9: Bit 25 (start of packet) and bit 24 (end of packet) of the status word are presented with the frame request.
- R10: A frame request stays asserted, with address and length unchanged, until it is accepted. A frame request and a memory request are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 (low 4 bits ignored) |
| cfg_ring_len | input | 16 | Two's complement of the number of ring entries |
| cfg_pad_en | input | 1 | Extend frames shorter than 64 bytes to 64 |
| mem_req | output | 1 | Descriptor memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 32-bit word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| fr_valid | output | 1 | Frame-fetch request valid |
| fr_ready | input | 1 | Frame-fetch unit accepts the request |
| fr_addr | output | 32 | Buffer start address |
| fr_len | output | 13 | Byte count to fetch (1 to 4096) |
| fr_sop | output | 1 | Start-of-packet marker of the descriptor |
| fr_eop | output | 1 | End-of-packet marker of the descriptor |
| tx_done | output | 1 | One-cycle pulse when a descriptor has been handed back after a request |
| desc_err | output | 1 | One-cycle pulse when a malformed descriptor has been handed back |

## Verification
The assertions take the ring base and ring length as constant between resets, and they expect the memory to answer each request with exactly one mem_ack before the walker moves on. If the ring length shrank while the walker was running, the index range check could fail even though the logic is correct. The bench changes the configuration only while reset is held. Its memory model acknowledges in the cycle after a request and then drops mem_ack for a cycle, so every access gets exactly one acknowledge. Descriptors are written into the model's memory at falling edges, so each entry is complete before the walker's next read.

// File: rtl/tdw_pkg.sv
package tdw_pkg;

    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int SOP_BIT    = 25;
    localparam int EOP_BIT    = 24;
    localparam int ONES_HI    = 15;
    localparam int ONES_LO    = 12;
    localparam int STAT_OFS   = 4;
    localparam int BUF_OFS    = 0;
    localparam int ENTRY_SHFT = 4;

    typedef enum logic [1:0] {
        ST_POLL,
        ST_FETCH_BUF,
        ST_ISSUE,
        ST_RETURN
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic              sop;
        logic              eop;
    } frame_hdr_t;

    function automatic logic stat_owned(input logic [WORD_W-1:0] w);
        return w[OWN_BIT];
    endfunction

    function automatic logic stat_well_formed(input logic [WORD_W-1:0] w);
        return &w[ONES_HI:ONES_LO];
    endfunction

    function automatic logic [WORD_W-1:0] stat_release(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[OWN_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/tdw_ring_index.sv
module tdw_ring_index #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] len_enc,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam int CNT_W = IDX_W + 1;

    logic [CNT_W-1:0] entries;
    logic [CNT_W-1:0] next_full;

    assign entries   = (CNT_W'(1) << IDX_W) - {1'b0, len_enc};
    assign next_full = {1'b0, idx} + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= (next_full == entries) ? '0 : next_full[IDX_W-1:0];
        end
    end

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, idx} < entries);

endmodule

// File: rtl/tdw_frame_len.sv
module tdw_frame_len #(
    parameter int LEN_W     = 12,
    parameter int MIN_FRAME = 64
) (
    input  logic [LEN_W-1:0] enc,
    input  logic             pad_en,
    output logic [LEN_W:0]   bytes
);
    localparam int CW = LEN_W + 1;
    localparam logic [CW-1:0] FLOOR = CW'(MIN_FRAME);

    logic [CW-1:0] raw;

    always_comb begin
        raw = (CW'(1) << LEN_W) - {1'b0, enc};
        if (pad_en && (raw < FLOOR)) begin
            bytes = FLOOR;
        end else begin
            bytes = raw;
        end
    end

endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
    import tdw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 16,
    parameter int LEN_W     = 12,
    parameter int MIN_FRAME = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [IDX_W-1:0]  cfg_ring_len,
    input  logic              cfg_pad_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              fr_valid,
    input  logic              fr_ready,
    output logic [WORD_W-1:0] fr_addr,
    output logic [LEN_W:0]    fr_len,
    output logic              fr_sop,
    output logic              fr_eop,
    output logic              tx_done,
    output logic              desc_err
);
    localparam int PAD_W = ADDR_W - IDX_W - ENTRY_SHFT;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ENTRY_SHFT) - 1);

    walk_state_e       state;
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] buf_q;
    logic              done_q;
    logic              err_q;
    logic [IDX_W-1:0]  idx;
    logic              step;
    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] entry_addr;
    frame_hdr_t        hdr;

    assign step = (state == ST_RETURN) && mem_ack;

    tdw_ring_index #(.IDX_W(IDX_W)) u_index (
        .clk     (clk),
        .rst     (rst),
        .len_enc (cfg_ring_len),
        .step    (step),
        .idx     (idx)
    );

    tdw_frame_len #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) u_len (
        .enc    (stat_q[LEN_W-1:0]),
        .pad_en (cfg_pad_en),
        .bytes  (fr_len)
    );

    assign base_al    = cfg_ring_base & ALIGN_MASK;
    assign entry_addr = base_al + {{PAD_W{1'b0}}, idx, {ENTRY_SHFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_POLL;
            stat_q <= '0;
            buf_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_POLL: begin
                    if (mem_ack) begin
                        stat_q <= mem_rdata;
                        if (stat_owned(mem_rdata)) begin
                            state <= stat_well_formed(mem_rdata) ? ST_FETCH_BUF : ST_RETURN;
                        end
                    end
                end
                ST_FETCH_BUF: begin
                    if (mem_ack) begin
                        buf_q <= mem_rdata;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (fr_ready) begin
                        state <= ST_RETURN;
                    end
                end
                ST_RETURN: begin
                    if (mem_ack) begin
                        done_q <= stat_well_formed(stat_q);
                        err_q  <= ~stat_well_formed(stat_q);
                        state  <= ST_POLL;
                    end
                end
                default: state <= ST_POLL;
            endcase
        end
    end

    always_comb begin
        hdr.addr = buf_q;
        hdr.sop  = stat_q[SOP_BIT];
        hdr.eop  = stat_q[EOP_BIT];
    end

    assign mem_req   = (state != ST_ISSUE);
    assign mem_we    = (state == ST_RETURN);
    assign mem_addr  = entry_addr + ((state == ST_FETCH_BUF) ? ADDR_W'(BUF_OFS) : ADDR_W'(STAT_OFS));
    assign mem_wdata = stat_release(stat_q);
    assign fr_valid  = (state == ST_ISSUE);
    assign fr_addr   = hdr.addr;
    assign fr_sop    = hdr.sop;
    assign fr_eop    = hdr.eop;
    assign tx_done   = done_q;
    assign desc_err  = err_q;

    // R10
    fr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fr_valid && !fr_ready |=> fr_valid && $stable(fr_addr) && $stable(fr_len));

    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fr_valid && mem_req));

    // R4
    pad_floor_chk: assert property (@(posedge clk) disable iff (rst)
        fr_valid && cfg_pad_en |-> fr_len >= (LEN_W+1)'(MIN_FRAME));

    // R5
    release_own_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

    // R5
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> $past(mem_req && mem_we && mem_ack));

    // R6
    event_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_done, desc_err}));

    // R2
    no_issue_unowned_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL) && mem_ack && !mem_rdata[OWN_BIT] |=> (state == ST_POLL) && !mem_we);

endmodule

// File: tb/sim_tx_desc_walker.sv
module sim_tx_desc_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_ring_base;
    logic [15:0] cfg_ring_len;
    logic        cfg_pad_en;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        fr_valid, fr_ready, fr_sop, fr_eop;
    logic [31:0] fr_addr;
    logic [12:0] fr_len;
    logic        tx_done, desc_err;

    always #5 clk = ~clk;

    tx_desc_walker u0 (
        .clk(clk), .rst(rst),
        .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len), .cfg_pad_en(cfg_pad_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_addr(fr_addr), .fr_len(fr_len),
        .fr_sop(fr_sop), .fr_eop(fr_eop), .tx_done(tx_done), .desc_err(desc_err)
    );

    typedef struct { logic [31:0] a; logic [12:0] l; logic s; logic e; } fexp_t;
    typedef struct { logic [31:0] a; logic [31:0] d; } wexp_t;
    fexp_t fq[$];
    wexp_t wq[$];

    logic [31:0] mem [0:4095];
    int checks = 0;
    int fails  = 0;
    int dones  = 0;
    int errs   = 0;
    int rcnt   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: one acknowledge per request, then a gap cycle
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[13:2]];
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // frame-fetch sink: accepts every third cycle
    always @(posedge clk) begin
        rcnt     <= rcnt + 1;
        fr_ready <= (rcnt % 3 == 2);
    end

    // monitor / scoreboard
    logic        held = 1'b0;
    logic [31:0] held_a;
    logic [12:0] held_l;
    always @(negedge clk) begin
        if (!rst) begin
            if (held) begin
                // R10 request held while not accepted
                chk(fr_valid && fr_addr == held_a && fr_len == held_l, "R10", "held request",
                    {fr_valid, fr_addr, 18'd0, fr_len}, {1'b1, held_a, 18'd0, held_l});
            end
            held   = fr_valid && !fr_ready;
            held_a = fr_addr;
            held_l = fr_len;
            if (fr_valid && fr_ready) begin
                if (fq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected frame request", {32'd0, fr_addr}, 64'd0);
                end else begin
                    fexp_t f;
                    f = fq.pop_front();
                    // R3 address and decoded count
                    chk(fr_addr == f.a, "R3", "frame addr", {32'd0, fr_addr}, {32'd0, f.a});
                    // R3 / R4 length
                    chk(fr_len == f.l, "R4", "frame len", {51'd0, fr_len}, {51'd0, f.l});
                    // R9 markers
                    chk({fr_sop, fr_eop} == {f.s, f.e}, "R9", "sop/eop",
                        {62'd0, fr_sop, fr_eop}, {62'd0, f.s, f.e});
                end
            end
            if (mem_req && mem_we && mem_ack) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write-back", {32'd0, mem_addr}, 64'd0);
                end else begin
                    wexp_t w;
                    w = wq.pop_front();
                    // R5 / R6 handback word
                    chk(mem_addr == w.a && mem_wdata == w.d, "R5", "write-back addr/data",
                        {mem_addr, mem_wdata}, {w.a, w.d});
                end
            end
            if (tx_done) dones++;
            if (desc_err) errs++;
        end
    end

    // driver: places a descriptor and queues its expected results
    task automatic put_desc(input int base, input int idx, input logic [31:0] bufa,
                            input logic [3:0] ones, input logic [11:0] enc,
                            input bit s, input bit e, input bit pad);
        logic [31:0] w1;
        logic [12:0] len;
        int          ea;
        fexp_t       f;
        wexp_t       w;
        ea = (base & ~32'hF) + idx * 16;
        w1 = {1'b1, 5'd0, s, e, 8'd0, ones, enc};
        mem[ea[13:2]]       = bufa;
        mem[(ea + 4) >> 2]  = w1;
        if (ones == 4'hF) begin
            len = 13'd4096 - {1'b0, enc};
            if (pad && len < 13'd64) len = 13'd64;
            f.a = bufa; f.l = len; f.s = s; f.e = e;
            fq.push_back(f);
        end
        w.a = ea + 4;
        w.d = w1 & 32'h7FFF_FFFF;
        wq.push_back(w);
    endtask

    task automatic drain();
        int t = 0;
        while ((fq.size() != 0 || wq.size() != 0) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R5", "queues drained", t, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] base, input logic [15:0] rlen, input logic pad);
        @(negedge clk);
        rst = 1'b1;
        cfg_ring_base = base;
        cfg_ring_len  = rlen;
        cfg_pad_en    = pad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int d0, e0;
        rst = 1'b1;
        cfg_ring_base = 32'h1000;
        cfg_ring_len  = 16'hFFFC;
        cfg_pad_en    = 1'b1;
        for (int i = 0; i < 4096; i++) mem[i] = 32'd0;

        // Phase A: four-entry ring, padding on
        do_reset(32'h1000, 16'hFFFC, 1'b1);
        // R1 reset state
        chk(!fr_valid && !mem_we && !tx_done && !desc_err, "R1", "idle outputs after reset",
            {60'd0, fr_valid, mem_we, tx_done, desc_err}, 64'd0);
        chk(mem_addr == 32'h1004 && mem_req, "R1", "first access",
            {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h1004});

        repeat (40) @(negedge clk);
        // R2 unowned entry polled again, nothing issued
        chk(mem_addr == 32'h1004 && !mem_we, "R2", "poll same entry",
            {31'd0, mem_we, mem_addr}, {32'd0, 32'h1004});
        chk(dones == 0 && errs == 0, "R2", "no events while unowned",
            {dones[31:0], errs[31:0]}, 64'd0);

        @(negedge clk);
        put_desc(32'h1000, 0, 32'hA000_0000, 4'hF, 12'hF9C, 1'b1, 1'b1, 1'b1); // 100 bytes
        put_desc(32'h1000, 1, 32'hB000_0010, 4'hF, 12'hFEC, 1'b1, 1'b1, 1'b1); // 20 -> 64 (R4)
        put_desc(32'h1000, 2, 32'hDEAD_0000, 4'hE, 12'hF00, 1'b0, 1'b0, 1'b1); // malformed (R6)
        put_desc(32'h1000, 3, 32'hC000_0000, 4'hF, 12'h000, 1'b1, 1'b0, 1'b1); // 4096 (R3)
        drain();
        // R5 one done per transmitted descriptor, R6 one error
        chk(dones == 3, "R5", "tx_done count", dones, 3);
        chk(errs == 1, "R6", "desc_err count", errs, 1);
        // R7 wrapped to entry 0
        chk(mem_addr == 32'h1004, "R7", "wrap to entry 0", mem_addr, 32'h1004);

        @(negedge clk);
        put_desc(32'h1000, 0, 32'hA100_0000, 4'hF, 12'hFC0, 1'b0, 1'b1, 1'b1); // exactly 64
        drain();
        chk(dones == 4, "R7", "entry 0 reused after wrap", dones, 4);
        chk(mem_addr == 32'h1014, "R7", "advance to entry 1", mem_addr, 32'h1014);

        // Phase B: single-entry ring, misaligned base, padding off
        do_reset(32'h2007, 16'hFFFF, 1'b0);
        // R8 low base bits ignored
        chk(mem_addr == 32'h2004, "R8", "aligned base", mem_addr, 32'h2004);
        d0 = dones;
        e0 = errs;
        @(negedge clk);
        put_desc(32'h2007, 0, 32'hD000_0004, 4'hF, 12'hFEC, 1'b0, 1'b0, 1'b0); // 20 unpadded (R4)
        drain();
        @(negedge clk);
        put_desc(32'h2007, 0, 32'hD100_0000, 4'hF, 12'hFFF, 1'b1, 1'b1, 1'b0); // 1 byte
        drain();
        chk(dones - d0 == 2 && errs == e0, "R7", "single-entry ring events",
            {dones[31:0] - d0[31:0], errs[31:0] - e0[31:0]}, {32'd2, 32'd0});
        chk(mem_addr == 32'h2004, "R7", "single-entry wrap", mem_addr, 32'h2004);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule